// File: doc/BRIEF.md
# Base-Limit Address Relocation Checker

This block turns a program-relative word address into an absolute memory address. It also keeps every access of the running task inside a protection window. The window is described by two 18-bit fields, a base and a limit. Each field holds a multiple of 16 words, and both are captured when the exchange controller installs a new task context. For each instruction fetch or operand access, the block adds the scaled base to the relative address and checks the result against the window. One cycle later it either issues a memory request carrying the absolute address, or it withholds the request.

When an access falls outside the window, the block sets a sticky flag, and the access kind decides which flag: an instruction fetch sets the program-range flag and a data access sets the operand-range flag. The block also pulses a task-end signal so the exchange controller can terminate the execution interval. The block then stays silent until a new context is loaded.

A small controller with three states sequences the block:

- **IDLE**: no context has been installed yet.
- **RUN**: a context is installed and accesses are accepted.
- **HALT**: a violation has ended the interval.

It has four transitions:

- IDLE→RUN on a context load.
- RUN→HALT on an accepted violating access.
- HALT→RUN on a context load.
- RUN→RUN on a context load, which is a reload.

Top module: `addr_window_guard`

## Requirements
- R1: After reset, rsp_valid, mem_req, task_end, prog_range_err and oper_range_err are all 0.
- R2: An access accepted in RUN produces, on the next cycle, rsp_valid=1 and mem_addr = (base*16 + rel_addr) modulo 2^22.
- R3: An access is a violation when its absolute address is below base*16 or at or above limit*16. The comparison is made on the 22-bit wrapped sum. A violating access gives mem_req=0 together with rsp_valid=1, and a legal access gives mem_req=1.
- R4: A violating access with req_is_fetch=1 sets prog_range_err. A violating access with req_is_fetch=0 sets oper_range_err.
- R5: The range flags are sticky: they stay set until a cycle with flag_clear=1 and are cleared on the next cycle. A violation in the same cycle as flag_clear still sets its flag.
- R6: A violation asserts task_end for exactly one cycle, together with the violating response, and enters HALT. In HALT, requests produce neither rsp_valid nor mem_req.
- R7: ctx_load=1 captures ctx_base and ctx_limit and enters RUN from any state. A request presented in the same cycle as ctx_load is dropped, giving rsp_valid=0 on the next cycle.
- R8: Changes on ctx_base and ctx_limit while ctx_load=0 have no effect on the translation or the bounds check.
- R9: Before the first context load (IDLE), requests are dropped and produce rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctx_load | input | 1 | Install new context bounds |
| ctx_base | input | 18 | Base in units of 16 words |
| ctx_limit | input | 18 | Limit in units of 16 words |
| flag_clear | input | 1 | Clear both range flags |
| req_valid | input | 1 | Access request |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| req_rel_addr | input | 22 | Relative word address |
| rsp_valid | output | 1 | Access was accepted last cycle |
| mem_req | output | 1 | Memory request for a legal access |
| mem_addr | output | 22 | Absolute address |
| task_end | output | 1 | One-cycle pulse: interval must end |
| prog_range_err | output | 1 | Sticky fetch range violation |
| oper_range_err | output | 1 | Sticky operand range violation |

## Verification
The hardest case to reach is a violation below the base. With an unsigned relative address, this case only occurs when the 22-bit sum wraps past the top of memory. The stimulus therefore installs a base near the top of the address space and sweeps relative addresses across the wrap point. Because every violation drops the block into HALT, the sweeps reload the context before each access. This lets each boundary address be observed from a fresh RUN state. A further case places a violation in the same cycle as flag_clear.

// File: rtl/awg_pkg.sv
package awg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } awg_state_t;
endpackage

// File: rtl/awg_xlate.sv
module awg_xlate #(
    parameter int BND_W  = 18,
    parameter int GRAN_W = 4,
    localparam int ADDR_W = BND_W + GRAN_W
) (
    input  logic [BND_W-1:0]  base_i,
    input  logic [BND_W-1:0]  limit_i,
    input  logic [ADDR_W-1:0] rel_i,
    output logic [ADDR_W-1:0] abs_o,
    output logic              viol_o
);
    logic [ADDR_W-1:0] base_abs;
    logic [ADDR_W-1:0] limit_abs;

    always_comb begin
        base_abs  = {base_i,  {GRAN_W{1'b0}}};
        limit_abs = {limit_i, {GRAN_W{1'b0}}};
        abs_o     = base_abs + rel_i;
        viol_o    = (abs_o < base_abs) || (abs_o >= limit_abs);
    end
endmodule

// File: rtl/awg_ctrl.sv
module awg_ctrl
    import awg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctx_load,
    input  logic req_valid,
    input  logic viol,
    output logic accept
);
    awg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctx_load) state_d = ST_RUN;
            ST_RUN: begin
                if (ctx_load)                    state_d = ST_RUN;
                else if (req_valid && viol)      state_d = ST_HALT;
            end
            ST_HALT: if (ctx_load) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = 1'b0;
            ST_RUN:  accept = req_valid && !ctx_load;
            ST_HALT: accept = 1'b0;
            default: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_window_guard.sv
module addr_window_guard #(
    parameter int BND_W  = 18,
    parameter int GRAN_W = 4,
    localparam int ADDR_W = BND_W + GRAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_load,
    input  logic [BND_W-1:0]  ctx_base,
    input  logic [BND_W-1:0]  ctx_limit,
    input  logic              flag_clear,
    input  logic              req_valid,
    input  logic              req_is_fetch,
    input  logic [ADDR_W-1:0] req_rel_addr,
    output logic              rsp_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              task_end,
    output logic              prog_range_err,
    output logic              oper_range_err
);
    logic [BND_W-1:0]  base_q, limit_q;
    logic [ADDR_W-1:0] abs_addr;
    logic              viol, accept;

    awg_xlate #(.BND_W(BND_W), .GRAN_W(GRAN_W)) u_xlate (
        .base_i (base_q),
        .limit_i(limit_q),
        .rel_i  (req_rel_addr),
        .abs_o  (abs_addr),
        .viol_o (viol)
    );

    awg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctx_load (ctx_load),
        .req_valid(req_valid),
        .viol     (viol),
        .accept   (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (ctx_load) begin
            base_q  <= ctx_base;
            limit_q <= ctx_limit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            mem_req        <= 1'b0;
            mem_addr       <= '0;
            task_end       <= 1'b0;
            prog_range_err <= 1'b0;
            oper_range_err <= 1'b0;
        end else begin
            rsp_valid <= accept;
            mem_req   <= accept && !viol;
            task_end  <= accept && viol;
            if (accept) mem_addr <= abs_addr;
            prog_range_err <= (accept && viol && req_is_fetch)
                           || (prog_range_err && !flag_clear);
            oper_range_err <= (accept && viol && !req_is_fetch)
                           || (oper_range_err && !flag_clear);
        end
    end
endmodule

// File: rtl/awg_checker.sv
module awg_checker (
    input logic clk,
    input logic rst_n,
    input logic ctx_load,
    input logic flag_clear,
    input logic rsp_valid,
    input logic mem_req,
    input logic task_end,
    input logic prog_range_err,
    input logic oper_range_err
);
    AST_REQ_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> rsp_valid); // R3
    AST_END_WITHHOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        task_end |-> (rsp_valid && !mem_req)); // R3
    AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        task_end |-> (prog_range_err || oper_range_err)); // R4
    AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_range_err && !flag_clear) |=> prog_range_err); // R5
    AST_OPER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_range_err && !flag_clear) |=> oper_range_err); // R5
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        task_end |=> !task_end); // R6
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        task_end |=> !rsp_valid); // R6
    AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> !rsp_valid); // R7
endmodule

bind addr_window_guard awg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctx_load      (ctx_load),
    .flag_clear    (flag_clear),
    .rsp_valid     (rsp_valid),
    .mem_req       (mem_req),
    .task_end      (task_end),
    .prog_range_err(prog_range_err),
    .oper_range_err(oper_range_err)
);

// File: tb/addr_window_guard_tb.sv
module addr_window_guard_tb;
    localparam int BW = 18;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctx_load = 1'b0;
    logic [BW-1:0] ctx_base = '0;
    logic [BW-1:0] ctx_limit = '0;
    logic          flag_clear = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_is_fetch = 1'b0;
    logic [AW-1:0] req_rel_addr = '0;
    logic          rsp_valid, mem_req, task_end, prog_range_err, oper_range_err;
    logic [AW-1:0] mem_addr;

    int n_vec = 0;
    int n_bad = 0;

    bit            m_run = 0;
    bit            m_prog = 0;
    bit            m_oper = 0;
    logic [BW-1:0] m_base = '0;
    logic [BW-1:0] m_limit = '0;

    always #5 clk = ~clk;

    addr_window_guard u_dut (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_base(ctx_base),
        .ctx_limit(ctx_limit), .flag_clear(flag_clear), .req_valid(req_valid),
        .req_is_fetch(req_is_fetch), .req_rel_addr(req_rel_addr),
        .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_addr(mem_addr),
        .task_end(task_end), .prog_range_err(prog_range_err),
        .oper_range_err(oper_range_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic load(input logic [BW-1:0] b, input logic [BW-1:0] l, input bit with_req);
        @(negedge clk);
        ctx_load = 1'b1; ctx_base = b; ctx_limit = l; flag_clear = 1'b1;
        req_valid = with_req; req_is_fetch = 1'b1; req_rel_addr = '0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 request with load dropped", rsp_valid, 0);
        ctx_load = 1'b0; flag_clear = 1'b0; req_valid = 1'b0;
        m_run = 1; m_prog = 0; m_oper = 0; m_base = b; m_limit = l;
    endtask

    task automatic access(input bit fetch, input logic [AW-1:0] rel, input bit clr);
        logic [AW-1:0] e_abs;
        logic [AW-1:0] b_abs;
        logic [AW-1:0] l_abs;
        bit e_viol;
        bit acc;
        b_abs = {m_base, 4'b0};
        l_abs = {m_limit, 4'b0};
        e_abs = b_abs + rel;
        e_viol = (e_abs < b_abs) || (e_abs >= l_abs);
        acc = m_run;
        @(negedge clk);
        req_valid = 1'b1; req_is_fetch = fetch; req_rel_addr = rel; flag_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; flag_clear = 1'b0;
        if (acc && e_viol) begin
            if (fetch) m_prog = 1; else m_oper = 1;
        end
        if (clr && !(acc && e_viol && fetch))  m_prog = 0;
        if (clr && !(acc && e_viol && !fetch)) m_oper = 0;
        if (clr && !acc) begin m_prog = 0; m_oper = 0; end
        chk(rsp_valid == acc, acc ? "R2 rsp_valid" : "R6/R9 dropped rsp_valid", rsp_valid, acc);
        chk(mem_req == (acc && !e_viol), "R3 mem_req", mem_req, acc && !e_viol);
        chk(task_end == (acc && e_viol), "R6 task_end", task_end, acc && e_viol);
        if (acc) chk(mem_addr == e_abs, "R2 mem_addr", mem_addr, e_abs);
        chk(prog_range_err == m_prog, "R4/R5 prog_range_err", prog_range_err, m_prog);
        chk(oper_range_err == m_oper, "R4/R5 oper_range_err", oper_range_err, m_oper);
        if (acc && e_viol) m_run = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rsp_valid == 0 && mem_req == 0 && task_end == 0, "R1 outputs idle", {rsp_valid, mem_req, task_end}, 0);
        chk(prog_range_err == 0 && oper_range_err == 0, "R1 flags clear", {prog_range_err, oper_range_err}, 0);
        rst_n = 1'b1;
        // R9 request before any context
        access(1, 22'h10, 0);
        access(0, 22'h0, 0);

        // sweep across both window edges; reload before each access
        for (int r = 0; r < 300; r++) begin
            load(18'h10, 18'h20, 0);
            access(r[0], AW'(r), 0);
        end
        // wrap past top of memory: below-base violation
        for (int r = 200; r < 320; r++) begin
            load(18'h3FFF0, 18'h3FFFF, 0);
            access(r[1], AW'(r), 0);
        end
        // empty window: limit at base
        for (int r = 0; r < 40; r++) begin
            load(18'h5, 18'h5, 0);
            access(r[0], AW'(r * 3), 0);
        end
        // R7 request in load cycle dropped
        load(18'h100, 18'h200, 1);
        // R8 bounds not changed without ctx_load
        ctx_base = 18'h0; ctx_limit = 18'h1;
        for (int r = 0; r < 20; r++) access(0, AW'(r * 100), 0);
        // R6 HALT is silent after violation
        load(18'h100, 18'h200, 0);
        access(1, 22'h2000, 0);
        access(1, 22'h10, 0);
        access(0, 22'h10, 0);
        // R5 flags stay set, then clear; violation with clear still sets
        access(0, 22'h10, 0);
        access(0, 22'h10, 1);
        load(18'h100, 18'h200, 0);
        access(0, 22'h3000, 1);
        access(0, 22'h0, 0);
        // R4 both flags
        load(18'h100, 18'h200, 0);
        access(1, 22'h1000, 0);
        load(18'h100, 18'h200, 0);
        m_prog = 0;
        access(0, 22'h1000, 0);
        // R5 a clear in HALT clears the flag
        access(1, 22'h5, 1);
        finish_run();
    end
endmodule